// File: doc/BRIEF.md
# Composite Peripheral Clock Generator

This block produces one peripheral clock from a choice of four reference clocks. The path runs through a source selector, a divide stage and an enable gate. A small bank of 32-bit registers holds the settings, and a plain memory-mapped bus writes and reads that bank. A build-time parameter picks the divide stage. It can be two cascaded 3-bit dividers whose ratios multiply, or one of three single-field lookup encodings. A fifth choice has no selector or divider and only gates a crystal input.

The block runs in one core clock domain. Each reference input and the crystal input is a one-cycle tick, and each tick marks one edge of that reference. The output is a registered waveform that toggles after N ticks of the selected source, where N is the total division ratio. Each output period is therefore N reference periods long, and the duty cycle is 50% for every ratio.

New selector, divider and gate settings are held back until the output finishes a low phase. The output therefore never shows a shortened pulse. Software can rewrite the registers at any time.

Top module: `cpg_periph_clk`

## Requirements
- R1: The bank holds six 32-bit words at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14. Address bits [4:2] pick the word. A write with bus_wr high stores all 32 bits at the rising clock edge. bus_rdata returns the addressed word in the same cycle with every bit exactly as written, including the invalid divider codes. Offsets 0x18 and 0x1C, and any address whose bits [1:0] are not 00, read as zero, and writes to them change no word.
- R2: Reset is synchronous and active-high. After reset every word reads zero except the divider word at 0x04, which reads 0x00000009. The 0x09 means that both divider fields (bits [5:3] and [2:0]) hold 1 and the selector holds 0. With these values the cascaded variant runs at divide-by-1 from reference 0.
- R3: Bits [5:4] of the word at 0x00 select which ref_tick input drives the divider. Values 0 to 3 select the input with that index.
- R4: When the total ratio is N, the output stays high for exactly N ticks of the selected source and then low for exactly N ticks.
- R5: In the cascaded variant, field A (bits [5:3] of 0x04) and field B (bits [2:0] of 0x04) each give a ratio equal to their value when that value is 1 to 6. The total ratio N is the product of the two.
- R6: If either cascaded field holds 0 or 7, the output is held low. Writing valid fields again restarts the output.
- R7: Bit 6 of the word at 0x14 is the disable bit. A 1 holds the output low, and a 0 lets it run. The other bits of that word have no effect on the output.
- R8: In the first single-field variant, bit 3 of 0x04 gives divide-by-1 when it is 0 and divide-by-2 when it is 1.
- R9: In the second single-field variant, bit 3 of 0x04 gives divide-by-2 when it is 0 and divide-by-4 when it is 1.
- R10: In the third single-field variant, bits [5:3] of 0x04 give a ratio equal to their value for 1 to 6. The values 0 and 7 hold the output low.
- R11: In the crystal-gate variant, the output toggles on every xtal_tick, subject only to the disable bit (R7). The selector and divider fields have no effect.
- R12: A new source, ratio or gate setting takes effect only at the end of a low phase of the output. The high phase and the low phase that are in progress when a register is written both complete with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| ref_tick | input | 4 | One tick per edge of each reference clock |
| xtal_tick | input | 1 | One tick per edge of the crystal clock |
| clk_out | output | 1 | Generated peripheral clock |

## Verification
The bench measures the high and low phase lengths in core cycles for several source periods and ratios. A design that multiplied the fields wrongly, or muxed in the wrong input, would show phases that do not equal ratio times source period. The bench also programs the codes 0 and 7 and sets the disable bit, then requires the output to stay low. A design that decoded 7 as a ratio, or ignored the gate, would keep toggling. The bench rewrites the ratio in the middle of a high phase and expects that high phase and the low phase after it to keep the old length. A design that applied settings at once would cut the phase short. Finally, the bench reads back invalid codes, misaligned addresses and unmapped offsets, which catches a bank that sanitises stored values or decodes addresses too loosely.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_REGS   = 6;
    localparam int SEL_IDX    = 0;
    localparam int DIS_IDX    = 5;
    localparam int NUM_REF    = 4;
    localparam int SEL_W      = $clog2(NUM_REF);
    localparam int FIELD_W    = 3;
    localparam int FIELD_MAX  = 6;
    localparam int NDIV_MAX   = FIELD_MAX * FIELD_MAX;
    localparam int NDIV_W     = $clog2(NDIV_MAX + 1);

    typedef enum logic [2:0] {
        DM_DOUBLE = 3'd0,
        DM_TABLE1 = 3'd1,
        DM_TABLE2 = 3'd2,
        DM_TABLE6 = 3'd3,
        DM_GATE   = 3'd4
    } div_mode_e;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_bank_t;

    typedef struct packed {
        logic              use_xtal;
        logic [SEL_W-1:0]  sel;
        logic [NDIV_W-1:0] ndiv;
        logic              run;
    } clk_cfg_t;

    // Ratio of one 3-bit field; zero marks an unusable code.
    function automatic logic [NDIV_W-1:0] field_ratio(input logic [FIELD_W-1:0] f);
        if (f == '0 || f > FIELD_W'(FIELD_MAX))
            return '0;
        return NDIV_W'(f);
    endfunction

endpackage

// File: rtl/cpg_regfile.sv
module cpg_regfile
    import cpg_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SEL_SHIFT   = 4,
    parameter int DIV_IDX_A   = 1,
    parameter int DIV_SHIFT_A = 3,
    parameter int DIV_IDX_B   = 1,
    parameter int DIV_SHIFT_B = 0,
    parameter int GATE_BIT    = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic [SEL_W-1:0]   sel_f,
    output logic [FIELD_W-1:0] field_a,
    output logic [FIELD_W-1:0] field_b,
    output logic               dis_f
);

    localparam int IDX_W = ADDR_W - 2;

    reg_bank_t        bank_q;
    logic [IDX_W-1:0] idx;
    logic             hit;

    assign idx = bus_addr[ADDR_W-1:2];
    assign hit = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        localparam logic [REG_W-1:0] RST_A = (i == DIV_IDX_A) ? (REG_W'(1) << DIV_SHIFT_A) : '0;
        localparam logic [REG_W-1:0] RST_B = (i == DIV_IDX_B) ? (REG_W'(1) << DIV_SHIFT_B) : '0;
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[i] <= RST_A | RST_B;
            else if (bus_wr && hit && idx == IDX_W'(i))
                bank_q[i] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit)
            bus_rdata = bank_q[idx];
    end

    assign sel_f   = bank_q[SEL_IDX][SEL_SHIFT +: SEL_W];
    assign field_a = bank_q[DIV_IDX_A][DIV_SHIFT_A +: FIELD_W];
    assign field_b = bank_q[DIV_IDX_B][DIV_SHIFT_B +: FIELD_W];
    assign dis_f   = bank_q[DIS_IDX][GATE_BIT];

    // R1
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr) && $past(hit)) |-> bank_q[$past(idx)] == $past(bus_wdata));

    // R2
    reset_fields_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (field_a == FIELD_W'(1) && field_b == FIELD_W'(1) && sel_f == '0 && !dis_f));

endmodule

// File: rtl/cpg_ratio_decode.sv
module cpg_ratio_decode
    import cpg_pkg::*;
#(
    parameter div_mode_e MODE = DM_DOUBLE
) (
    input  logic [SEL_W-1:0]   sel_f,
    input  logic [FIELD_W-1:0] field_a,
    input  logic [FIELD_W-1:0] field_b,
    input  logic               dis_f,
    output clk_cfg_t           cfg
);

    logic [NDIV_W-1:0] ratio;

    always_comb begin
        case (MODE)
            DM_DOUBLE: ratio = NDIV_W'(field_ratio(field_a) * field_ratio(field_b));
            DM_TABLE1: ratio = field_a[0] ? NDIV_W'(2) : NDIV_W'(1);
            DM_TABLE2: ratio = field_a[0] ? NDIV_W'(4) : NDIV_W'(2);
            DM_TABLE6: ratio = field_ratio(field_a);
            default:   ratio = NDIV_W'(1);
        endcase
        cfg.use_xtal = (MODE == DM_GATE);
        cfg.sel      = (MODE == DM_GATE) ? '0 : sel_f;
        cfg.ndiv     = ratio;
        cfg.run      = (ratio != '0) && !dis_f;
    end

endmodule

// File: rtl/cpg_core.sv
module cpg_core
    import cpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REF-1:0] ref_tick,
    input  logic               xtal_tick,
    input  clk_cfg_t           cfg_in,
    output logic               clk_out
);

    clk_cfg_t          act;
    logic [NDIV_W-1:0] cnt;
    logic              out_q;
    logic              tick;
    logic              phase_end;

    assign tick      = act.use_xtal ? xtal_tick : ref_tick[act.sel];
    assign phase_end = tick && (cnt == act.ndiv - NDIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= '0;
            cnt   <= '0;
            out_q <= 1'b0;
        end else if (!act.run) begin
            act <= cfg_in;
            cnt <= '0;
        end else if (phase_end) begin
            cnt <= '0;
            if (out_q) begin
                out_q <= 1'b0;
            end else begin
                act   <= cfg_in;
                out_q <= cfg_in.run;
            end
        end else if (tick) begin
            cnt <= cnt + NDIV_W'(1);
        end
    end

    assign clk_out = out_q;

    // R12
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_q |=> $stable(act));

    // R6
    stop_low_chk: assert property (@(posedge clk) disable iff (rst)
        !act.run |-> !out_q);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        act.run |-> (cnt < act.ndiv));

    // R7
    gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> act.run);

endmodule

// File: rtl/cpg_periph_clk.sv
module cpg_periph_clk
    import cpg_pkg::*;
#(
    parameter div_mode_e MODE  = DM_DOUBLE,
    parameter int ADDR_W       = 5,
    parameter int SEL_SHIFT    = 4,
    parameter int DIV_IDX_A    = 1,
    parameter int DIV_SHIFT_A  = 3,
    parameter int DIV_IDX_B    = 1,
    parameter int DIV_SHIFT_B  = 0,
    parameter int GATE_BIT     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        ref_tick,
    input  logic              xtal_tick,
    output logic              clk_out
);

    logic [SEL_W-1:0]   sel_f;
    logic [FIELD_W-1:0] field_a;
    logic [FIELD_W-1:0] field_b;
    logic               dis_f;
    clk_cfg_t           cfg;

    cpg_regfile #(
        .ADDR_W(ADDR_W), .SEL_SHIFT(SEL_SHIFT),
        .DIV_IDX_A(DIV_IDX_A), .DIV_SHIFT_A(DIV_SHIFT_A),
        .DIV_IDX_B(DIV_IDX_B), .DIV_SHIFT_B(DIV_SHIFT_B),
        .GATE_BIT(GATE_BIT)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sel_f(sel_f), .field_a(field_a), .field_b(field_b), .dis_f(dis_f)
    );

    cpg_ratio_decode #(.MODE(MODE)) u_dec (
        .sel_f(sel_f), .field_a(field_a), .field_b(field_b), .dis_f(dis_f), .cfg(cfg)
    );

    cpg_core u_core (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .xtal_tick(xtal_tick),
        .cfg_in(cfg), .clk_out(clk_out)
    );

endmodule

// File: tb/sim_cpg_periph_clk.sv
module sim_cpg_periph_clk;
    import cpg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1, rdata2, rdata3, rdata4;
    logic [3:0]  ref_tick = 4'b0001;
    logic        xtal_tick = 1'b1;
    logic [4:0]  outs;

    int checks = 0;
    int fails  = 0;
    int tcount = 0;

    always #2 clk = ~clk;

    cpg_periph_clk #(.MODE(DM_DOUBLE)) u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .ref_tick(ref_tick), .xtal_tick(xtal_tick), .clk_out(outs[0]));
    cpg_periph_clk #(.MODE(DM_TABLE1)) u1 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .ref_tick(ref_tick), .xtal_tick(xtal_tick), .clk_out(outs[1]));
    cpg_periph_clk #(.MODE(DM_TABLE2)) u2 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata2), .ref_tick(ref_tick), .xtal_tick(xtal_tick), .clk_out(outs[2]));
    cpg_periph_clk #(.MODE(DM_TABLE6)) u3 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata3), .ref_tick(ref_tick), .xtal_tick(xtal_tick), .clk_out(outs[3]));
    cpg_periph_clk #(.MODE(DM_GATE)) u4 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata4), .ref_tick(ref_tick), .xtal_tick(xtal_tick), .clk_out(outs[4]));

    // reference k ticks once every k+1 cycles; crystal ticks every cycle
    initial begin
        forever begin
            @(negedge clk);
            tcount++;
            ref_tick[1] = (tcount % 2 == 0);
            ref_tick[2] = (tcount % 3 == 0);
            ref_tick[3] = (tcount % 4 == 0);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = rdata0;
    endtask

    task automatic get_phase(input int k, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        while (outs[k] !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        while (outs[k] !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
        while (outs[k] === 1'b1 && guard < 5000) begin hi++; @(negedge clk); guard++; end
        while (outs[k] === 1'b0 && guard < 5000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic steady(input string tag, input int k, input int exp);
        int hi, lo;
        get_phase(k, hi, lo);
        get_phase(k, hi, lo);
        chk({tag, " high"}, hi, exp);
        chk({tag, " low"}, lo, exp);
    endtask

    task automatic held_low(input string tag, input int k);
        int highs = 0;
        repeat (400) @(negedge clk);
        repeat (200) begin
            if (outs[k] === 1'b1) highs++;
            @(negedge clk);
        end
        chk(tag, highs, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(5'h00, d); chk("R2 select word", int'(d), 0);
        rd(5'h04, d); chk("R2 divider word", int'(d), 9);
        rd(5'h08, d); chk("R2 word 0x08", int'(d), 0);
        rd(5'h10, d); chk("R2 word 0x10", int'(d), 0);
        rd(5'h14, d); chk("R2 disable word", int'(d), 0);
        steady("R2 cascaded div1", 0, 1);
        steady("R8 table1 reset div2", 1, 2);
    endtask

    task automatic t_cascade;
        wr(5'h04, 32'h13);
        steady("R5 R4 ratio 2x3", 0, 6);
        wr(5'h04, 32'h36);
        steady("R5 ratio 6x6", 0, 36);
        wr(5'h04, 32'h0C);
        steady("R5 ratio 1x4", 0, 4);
    endtask

    task automatic t_source;
        wr(5'h04, 32'h13);
        wr(5'h00, 32'h20);
        steady("R3 source 2 ratio 6", 0, 18);
        wr(5'h04, 32'h0A);
        wr(5'h00, 32'h30);
        steady("R3 source 3 ratio 2", 0, 8);
        wr(5'h00, 32'h10);
        steady("R3 source 1 ratio 2", 0, 4);
        wr(5'h00, 32'h00);
    endtask

    task automatic t_invalid;
        logic [31:0] d;
        wr(5'h04, 32'h3F);
        rd(5'h04, d); chk("R1 readback code 7", int'(d), 32'h3F);
        held_low("R6 field code 7", 0);
        wr(5'h04, 32'h18);
        held_low("R6 field code 0", 0);
        wr(5'h04, 32'h0F);
        held_low("R6 field B code 7", 0);
        wr(5'h04, 32'h09);
        steady("R6 restart div1", 0, 1);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        wr(5'h04, 32'h0A);
        wr(5'h14, 32'h40);
        rd(5'h14, d); chk("R1 readback disable", int'(d), 32'h40);
        held_low("R7 disable set", 0);
        wr(5'h14, 32'hFFFF_FFBF);
        steady("R7 other bits ignored", 0, 2);
        wr(5'h14, 32'h0);
    endtask

    task automatic t_tables;
        wr(5'h04, 32'h00);
        steady("R8 table1 bit 0", 1, 1);
        steady("R9 table2 bit 0", 2, 2);
        held_low("R10 table6 code 0", 3);
        wr(5'h04, 32'h08);
        steady("R8 table1 bit 1", 1, 2);
        steady("R9 table2 bit 1", 2, 4);
        steady("R10 table6 code 1", 3, 1);
        wr(5'h04, 32'h28);
        steady("R10 table6 code 5", 3, 5);
        wr(5'h04, 32'h38);
        held_low("R10 table6 code 7", 3);
    endtask

    task automatic t_xtal;
        wr(5'h04, 32'h38);
        wr(5'h00, 32'h30);
        steady("R11 crystal ignores fields", 4, 1);
        wr(5'h14, 32'h40);
        held_low("R11 crystal disabled", 4);
        wr(5'h14, 32'h0);
        steady("R11 crystal reenabled", 4, 1);
        wr(5'h00, 32'h00);
    endtask

    task automatic t_decode;
        logic [31:0] d;
        wr(5'h04, 32'h09);
        wr(5'h18, 32'hDEAD);
        rd(5'h18, d); chk("R1 offset 0x18 reads zero", int'(d), 0);
        rd(5'h05, d); chk("R1 misaligned read zero", int'(d), 0);
        wr(5'h06, 32'h123);
        rd(5'h04, d); chk("R1 misaligned write ignored", int'(d), 9);
        wr(5'h10, 32'hA5A5);
        rd(5'h10, d); chk("R1 readback 0x10", int'(d), 32'hA5A5);
        wr(5'h0C, 32'h7777_7777);
        rd(5'h0C, d); chk("R1 readback 0x0C", int'(d), 32'h7777_7777);
    endtask

    task automatic t_glitch;
        int hi = 0, lo = 0, hi2 = 0, lo2 = 0;
        int guard = 0;
        wr(5'h04, 32'h13);
        steady("R12 setup ratio 6", 0, 6);
        while (outs[0] !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        while (outs[0] !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
        hi = 1;
        bus_addr = 5'h04; bus_wdata = 32'h0A; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        while (outs[0] === 1'b1 && guard < 5000) begin hi++; @(negedge clk); guard++; end
        while (outs[0] === 1'b0 && guard < 5000) begin lo++; @(negedge clk); guard++; end
        while (outs[0] === 1'b1 && guard < 5000) begin hi2++; @(negedge clk); guard++; end
        while (outs[0] === 1'b0 && guard < 5000) begin lo2++; @(negedge clk); guard++; end
        chk("R12 current high keeps old ratio", hi, 6);
        chk("R12 current low keeps old ratio", lo, 6);
        chk("R12 next high uses new ratio", hi2, 2);
        chk("R12 next low uses new ratio", lo2, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cascade();
        t_source();
        t_invalid();
        t_gate();
        t_tables();
        t_xtal();
        t_decode();
        t_glitch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule